// File: doc/BRIEF.md
# Posted Auto-Refresh Scheduler

This block tracks how much refresh a DDR SDRAM still owes, and tells the command arbiter when to issue AUTO REFRESH. An internal interval timer adds one unit of refresh debt every refresh period, which averages 7.8125 µs. While debt is owed, a soft request stays high, so the arbiter can postpone refreshes behind ordinary traffic and issue several in a row later. Once postponing is no longer safe, an urgent request is raised. Postponing stops being safe when the debt reaches the postponement limit of eight, or when the time since the last refresh approaches nine refresh periods.

The arbiter pulses an acknowledge in the cycle it issues AUTO REFRESH. That refresh clears one unit of debt and opens a refresh-cycle-time window. During the window a busy output blocks other commands, and a clock-enable hold output tells the pad logic that CKE must stay high. Row addresses are generated inside the memory, so this block carries no address.

A sticky error flag is raised if the debt ever goes past the postponement limit. The block does not handle precharging banks before a refresh, self-refresh, or arbitration.

Top module: `refresh_posting_sched`

## Requirements
- R1: While reset is high, and on the first sample after reset, debt is 0 and ref_req, ref_urgent, rfc_busy, cke_hold and overflow_err are all low.
- R2: Debt rises by one at the end of every TREFI_CYC clock cycles, counted from the release of reset. The first increment appears after exactly TREFI_CYC rising edges with reset low.
- R3: ref_req is high exactly when debt is nonzero.
- R4: Each accepted acknowledge lowers debt by one. An accepted acknowledge while debt is 0 leaves debt at 0. An accepted acknowledge in the same cycle that the interval timer expires leaves debt unchanged.
- R5: ref_urgent is high whenever debt is at least POSTPONE_MAX (8).
- R6: ref_urgent is also high once GAP_INTERVALS×TREFI_CYC − URGENT_MARGIN cycles have passed since the last accepted acknowledge (or since reset), even when debt is below POSTPONE_MAX. An accepted acknowledge restarts that count.
- R7: rfc_busy goes high on the edge that accepts an acknowledge and stays high for exactly TRFC_CYC cycles.
- R8: cke_hold is high combinationally in the cycle ref_ack is presented, and throughout every cycle in which rfc_busy is high.
- R9: An acknowledge presented while rfc_busy is high is ignored. It does not change debt, does not lengthen the busy window, and does not restart the gap count.
- R10: Debt saturates at POSTPONE_MAX+1. overflow_err rises on the edge where debt reaches POSTPONE_MAX+1 and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack | input | 1 | AUTO REFRESH issued by the arbiter this cycle |
| ref_req | output | 1 | Soft request: refresh debt is owed |
| ref_urgent | output | 1 | Refresh must not be postponed further |
| rfc_busy | output | 1 | Refresh-cycle-time window active; block other commands |
| cke_hold | output | 1 | CKE must be held high |
| debt | output | DEBT_W ($clog2(POSTPONE_MAX+2)) | Outstanding refresh count |
| overflow_err | output | 1 | Sticky: debt went past POSTPONE_MAX |

## Verification
The bound checker looks at every cycle. It checks that debt never moves by more than one step per edge, that debt reaching the limit always raises urgency, that an accepted acknowledge always opens a busy window no longer than TRFC_CYC, that cke_hold covers that window, and that an acknowledge arriving during the window leaves debt untouched. Other behaviour depends on exact timing and only the bench scenarios can show it. These are the exact cycle of the first debt increment, the urgency raised by the elapsed gap alone while debt is still six, the exact cycle when the busy window closes, acknowledges landing on the same edge as an interval expiry, and the saturation and stickiness of the overflow flag.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    // Action taken on the refresh debt in one cycle.
    typedef enum logic [1:0] {
        DEBT_HOLD = 2'd0,
        DEBT_ADD  = 2'd1,
        DEBT_PAY  = 2'd2
    } debt_op_e;

    // Request pair presented to the command arbiter.
    typedef struct packed {
        logic pending;
        logic urgent;
    } refresh_req_t;

    // An interval expiry and a paid refresh in the same cycle cancel.
    // A payment with nothing owed is dropped, so the debt cannot go negative.
    function automatic debt_op_e pick_debt_op(input logic expiry,
                                              input logic paid,
                                              input logic owed);
        debt_op_e op;
        if (expiry && !paid)
            op = DEBT_ADD;
        else if (!expiry && paid && owed)
            op = DEBT_PAY;
        else
            op = DEBT_HOLD;
        return op;
    endfunction

    function automatic int unsigned width_for(input int unsigned max_value);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(max_value))
            w++;
        return w;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import refresh_sched_pkg::*;
#(
    parameter int unsigned PERIOD = 1953
) (
    input  logic clk,
    input  logic rst,
    output logic expiry
);
    localparam int unsigned CW = width_for(PERIOD - 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (count_q == LAST)
            count_q <= '0;
        else
            count_q <= count_q + 1'b1;
    end

    assign expiry = (count_q == LAST);
endmodule

// File: rtl/refresh_debt_ledger.sv
module refresh_debt_ledger
    import refresh_sched_pkg::*;
#(
    parameter int unsigned LIMIT = 8,
    parameter int unsigned DW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expiry,
    input  logic          paid,
    output logic [DW-1:0] owed,
    output logic          overflow
);
    localparam logic [DW-1:0] CAP     = DW'(LIMIT + 1);
    localparam logic [DW-1:0] LIMIT_W = DW'(LIMIT);

    logic [DW-1:0] owed_q, owed_nx;
    logic          ovf_q;
    debt_op_e      op;

    always_comb begin
        op      = pick_debt_op(expiry, paid, owed_q != '0);
        owed_nx = owed_q;
        unique case (op)
            DEBT_ADD: if (owed_q != CAP) owed_nx = owed_q + 1'b1;
            DEBT_PAY: owed_nx = owed_q - 1'b1;
            default:  owed_nx = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            owed_q <= owed_nx;
            ovf_q  <= ovf_q | (owed_nx > LIMIT_W);
        end
    end

    assign owed     = owed_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/refresh_gap_monitor.sv
module refresh_gap_monitor
    import refresh_sched_pkg::*;
#(
    parameter int unsigned SPAN_CYC   = 17577,
    parameter int unsigned THRESH_CYC = 17513
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic near_limit
);
    localparam int unsigned GW = width_for(SPAN_CYC);
    localparam logic [GW-1:0] SPAN   = GW'(SPAN_CYC);
    localparam logic [GW-1:0] THRESH = GW'(THRESH_CYC);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            gap_q <= '0;
        else if (gap_q != SPAN)
            gap_q <= gap_q + 1'b1;
    end

    assign near_limit = (gap_q >= THRESH);
endmodule

// File: rtl/refresh_rfc_window.sv
module refresh_rfc_window
    import refresh_sched_pkg::*;
#(
    parameter int unsigned TRFC_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic accepted,
    output logic busy,
    output logic cke_hold
);
    localparam int unsigned RW = width_for(TRFC_CYC);
    localparam logic [RW-1:0] LOAD = RW'(TRFC_CYC);

    logic [RW-1:0] remain_q;

    assign busy     = (remain_q != '0);
    assign accepted = grant && !busy;
    assign cke_hold = grant || busy;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (accepted)
            remain_q <= LOAD;
        else if (busy)
            remain_q <= remain_q - 1'b1;
    end
endmodule

// File: rtl/refresh_posting_sched.sv
module refresh_posting_sched
    import refresh_sched_pkg::*;
#(
    parameter int unsigned TREFI_CYC     = 1953,
    parameter int unsigned TRFC_CYC      = 20,
    parameter int unsigned POSTPONE_MAX  = 8,
    parameter int unsigned GAP_INTERVALS = 9,
    parameter int unsigned URGENT_MARGIN = 64,
    parameter int unsigned DEBT_W        = $clog2(POSTPONE_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              rfc_busy,
    output logic              cke_hold,
    output logic [DEBT_W-1:0] debt,
    output logic              overflow_err
);
    localparam int unsigned GAP_CYC    = GAP_INTERVALS * TREFI_CYC;
    localparam int unsigned GAP_THRESH = (URGENT_MARGIN < GAP_CYC) ? GAP_CYC - URGENT_MARGIN : 1;
    localparam logic [DEBT_W-1:0] URGENT_DEBT = DEBT_W'(POSTPONE_MAX);

    logic         interval_tick;
    logic         grant_taken;
    logic         gap_near;
    refresh_req_t req_s;

    refresh_interval_timer #(.PERIOD(TREFI_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .expiry (interval_tick)
    );

    refresh_rfc_window #(.TRFC_CYC(TRFC_CYC)) u_window (
        .clk      (clk),
        .rst      (rst),
        .grant    (ref_ack),
        .accepted (grant_taken),
        .busy     (rfc_busy),
        .cke_hold (cke_hold)
    );

    refresh_debt_ledger #(.LIMIT(POSTPONE_MAX), .DW(DEBT_W)) u_ledger (
        .clk      (clk),
        .rst      (rst),
        .expiry   (interval_tick),
        .paid     (grant_taken),
        .owed     (debt),
        .overflow (overflow_err)
    );

    refresh_gap_monitor #(.SPAN_CYC(GAP_CYC), .THRESH_CYC(GAP_THRESH)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .restart    (grant_taken),
        .near_limit (gap_near)
    );

    always_comb begin
        req_s.pending = (debt != '0);
        req_s.urgent  = (debt >= URGENT_DEBT) || gap_near;
    end

    assign ref_req    = req_s.pending;
    assign ref_urgent = req_s.urgent;
endmodule

// File: rtl/refresh_posting_sched_chk.sv
module refresh_posting_sched_chk #(
    parameter int unsigned TRFC_CYC     = 20,
    parameter int unsigned POSTPONE_MAX = 8,
    parameter int unsigned DEBT_W       = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_ack,
    input logic              interval_tick,
    input logic              ref_req,
    input logic              ref_urgent,
    input logic              rfc_busy,
    input logic              cke_hold,
    input logic [DEBT_W-1:0] debt,
    input logic              overflow_err
);
    localparam int unsigned RUN_W = $clog2(TRFC_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(TRFC_CYC + 1);

    logic [RUN_W-1:0] busy_run_q;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run_q <= '0;
        else if (rfc_busy && busy_run_q != RUN_CAP)
            busy_run_q <= busy_run_q + 1'b1;
        else if (!rfc_busy)
            busy_run_q <= '0;
    end

    AST_REQ_TRACKS_DEBT: assert property (@(posedge clk) disable iff (rst)
        ref_req == (debt != '0));                                             // R3
    AST_DEBT_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(debt) <= int'($past(debt)) + 1) && (int'(debt) + 1 >= int'($past(debt)))); // R4
    AST_TICK_ADDS: assert property (@(posedge clk) disable iff (rst)
        interval_tick && !ref_ack && (int'(debt) <= int'(POSTPONE_MAX)) |=> int'(debt) == int'($past(debt)) + 1); // R2
    AST_URGENT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (int'(debt) >= int'(POSTPONE_MAX)) |-> ref_urgent);                   // R5
    AST_GRANT_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ref_ack && !rfc_busy |=> rfc_busy);                                   // R7
    AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (rst)
        int'(busy_run_q) <= int'(TRFC_CYC));                                  // R7
    AST_CKE_COVERS: assert property (@(posedge clk) disable iff (rst)
        (rfc_busy || ref_ack) |-> cke_hold);                                  // R8
    AST_BUSY_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ref_ack && rfc_busy && !interval_tick |=> $stable(debt));             // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(debt) <= int'(POSTPONE_MAX) + 1);                                // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);                                       // R10
    AST_ERR_WITH_DEBT: assert property (@(posedge clk) disable iff (rst)
        (int'(debt) > int'(POSTPONE_MAX)) |-> overflow_err);                  // R10
endmodule

bind refresh_posting_sched refresh_posting_sched_chk #(
    .TRFC_CYC     (TRFC_CYC),
    .POSTPONE_MAX (POSTPONE_MAX),
    .DEBT_W       (DEBT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ref_ack       (ref_ack),
    .interval_tick (interval_tick),
    .ref_req       (ref_req),
    .ref_urgent    (ref_urgent),
    .rfc_busy      (rfc_busy),
    .cke_hold      (cke_hold),
    .debt          (debt),
    .overflow_err  (overflow_err)
);

// File: tb/refresh_posting_sched_bench.sv
`timescale 1ns/1ps
module refresh_posting_sched_bench;
    localparam int unsigned TREFI  = 16;
    localparam int unsigned TRFC   = 4;
    localparam int unsigned PMAX   = 8;
    localparam int unsigned GAPN   = 9;
    localparam int unsigned MARGIN = 40;
    localparam int unsigned DW     = $clog2(PMAX + 2);

    typedef struct packed {
        logic [7:0] idle;
        logic       ack;
        logic [3:0] debt;
        logic       req;
        logic       urg;
        logic       busy;
        logic       err;
    } vec_t;

    // idle cycles, then one cycle carrying ack; then expected outputs
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},  // edge 1: ack with zero debt
        '{8'd2,   1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},  // edge 4: ack while busy, ignored
        '{8'd0,   1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // edge 5: window closed, not extended
        '{8'd10,  1'b0, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // edge 16: first interval
        '{8'd15,  1'b0, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0},  // edge 32
        '{8'd0,   1'b1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // edge 33: pay one
        '{8'd14,  1'b1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // edge 48: pay on expiry edge
        '{8'd0,   1'b1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // edge 49: busy, ignored
        '{8'd4,   1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0},  // edge 54: accepted
        '{8'd102, 1'b0, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0},  // edge 157: gap 103
        '{8'd0,   1'b0, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0},  // edge 158: gap urgency
        '{8'd17,  1'b0, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0},  // edge 176
        '{8'd0,   1'b1, 4'd7, 1'b1, 1'b0, 1'b1, 1'b0},  // edge 177: gap restarts
        '{8'd14,  1'b0, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0},  // edge 192: debt urgency
        '{8'd15,  1'b0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b1},  // edge 208: overflow
        '{8'd15,  1'b0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b1},  // edge 224: saturated
        '{8'd0,   1'b1, 4'd8, 1'b1, 1'b1, 1'b1, 1'b1},  // edge 225: flag sticky
        '{8'd4,   1'b1, 4'd7, 1'b1, 1'b0, 1'b1, 1'b1}   // edge 230: first edge after window
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_ack = 1'b0;
    logic          ref_req, ref_urgent, rfc_busy, cke_hold, overflow_err;
    logic [DW-1:0] debt;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    refresh_posting_sched #(
        .TREFI_CYC     (TREFI),
        .TRFC_CYC      (TRFC),
        .POSTPONE_MAX  (PMAX),
        .GAP_INTERVALS (GAPN),
        .URGENT_MARGIN (MARGIN)
    ) u_refresh_posting_sched (
        .clk          (clk),
        .rst          (rst),
        .ref_ack      (ref_ack),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .rfc_busy     (rfc_busy),
        .cke_hold     (cke_hold),
        .debt         (debt),
        .overflow_err (overflow_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_idle_state(input string tag);
        check({tag, " R1 debt"}, int'(debt), 0);
        check({tag, " R1 ref_req"}, int'(ref_req), 0);
        check({tag, " R1 ref_urgent"}, int'(ref_urgent), 0);
        check({tag, " R1 rfc_busy"}, int'(rfc_busy), 0);
        check({tag, " R1 cke_hold"}, int'(cke_hold), 0);
        check({tag, " R1 overflow_err"}, int'(overflow_err), 0);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic one_cycle(input logic ack);
        ref_ack = ack;
        if (ack) begin
            #1;
            check("R8 cke_hold with ack", int'(cke_hold), 1);
        end
        @(posedge clk);
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check_idle_state("reset held");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < int'(VEC[v].idle); i++)
                one_cycle(1'b0);
            one_cycle(VEC[v].ack);
            check($sformatf("R2 R4 R10 debt v%0d", v), int'(debt), int'(VEC[v].debt));
            check($sformatf("R3 ref_req v%0d", v), int'(ref_req), int'(VEC[v].req));
            check($sformatf("R5 R6 ref_urgent v%0d", v), int'(ref_urgent), int'(VEC[v].urg));
            check($sformatf("R7 R9 rfc_busy v%0d", v), int'(rfc_busy), int'(VEC[v].busy));
            if (VEC[v].busy)
                check($sformatf("R8 cke_hold in window v%0d", v), int'(cke_hold), 1);
            check($sformatf("R10 overflow_err v%0d", v), int'(overflow_err), int'(VEC[v].err));
        end

        // Reset in the middle of a busy window with the error set
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idle_state("mid-run reset");
        rst = 1'b0;

        // R2: one edge short of the interval, then exactly on it
        for (int i = 0; i < int'(TREFI) - 1; i++)
            one_cycle(1'b0);
        check("R2 debt before first interval", int'(debt), 0);
        one_cycle(1'b0);
        check("R2 debt at first interval", int'(debt), 1);

        // R7: window length measured at the ports
        one_cycle(1'b1);
        check("R4 debt after pay", int'(debt), 0);
        for (int i = 1; i < int'(TRFC); i++) begin
            one_cycle(1'b0);
            check("R7 busy inside window", int'(rfc_busy), 1);
        end
        one_cycle(1'b0);
        check("R7 busy after window", int'(rfc_busy), 0);
        check("R8 cke_hold released", int'(cke_hold), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule